// File: doc/BRIEF.md
# LCD Drive Waveform Generator

This block turns a bank of stored display bits and a few control fields into drive-level codes for an LCD panel with two common electrodes and 54 segment electrodes. Every output pin gets a 2-bit level code. Code 00 means ground, 01 means half supply and 10 means full supply. Code 11 is never produced. An analog output stage outside this block turns the codes into voltages.

Frame timing comes from a single-cycle oscillator tick that acts as a clock enable. A rate selector picks how many accepted ticks make up one frame. The frame is split into four equal quarters. The panel can be driven in one of two ways:

- Static drive: one active common.
- Two-phase drive: both commons active, half bias.

Three overrides can blank the panel:

- A blanking control that outputs the off waveform on the segments.
- A power-save control that grounds the panel and freezes the timing.
- An active-low inhibit input that grounds everything.

The first four segment pins can instead serve as plain high/low output ports.

Top module: `lcd_wave_gen`

## Requirements
- R1: A frame lasts D accepted ticks, and each quarter lasts D/4 ticks. D depends on `rate_sel` as follows: 110→768, 111→576, 000→384, 001→288, 010→192. Any other code gives 384. If the quarter counter is already at or past the end of a newly selected quarter length, the quarter ends on the next accepted tick.
- R2: A tick is accepted only when `osc_tick`=1, `inhibit_n`=1 and `psave`=0. With no accepted tick, the quarter position stays where it is. After reset, the block is at the start of quarter 0.
- R3: In static drive (`duty2`=0), common 1 (`com_lvl[1:0]`) is full supply in quarters 0–1 and ground in quarters 2–3. Common 2 (`com_lvl[3:2]`) stays at ground.
- R4: In static drive, segment pin n (`seg_lvl[2n-1:2n-2]`) uses display bit Dn (`disp_bits[n-1]`). An off segment copies common 1. An on segment drives the opposite rail.
- R5: In two-phase drive (`duty2`=1), quarter q selects common 1 for q=0 and q=2, and common 2 for q=1 and q=3. The selected common is full supply in quarters 0–1 and ground in quarters 2–3. The other common is at half supply.
- R6: In two-phase drive, segment pin n uses D(2n−1) while common 1 is selected and D(2n) while common 2 is selected. An on segment drives the rail opposite to the selected common. An off segment drives the same rail.
- R7: When `blank`=1, every segment pin that is not a port outputs the off waveform (the selected common's rail). The commons keep running.
- R8: When `psave`=1 (and `inhibit_n`=1), both commons and every non-port segment pin are at ground. Port pins keep outputting their data.
- R9: When `inhibit_n`=0, every common and segment pin is at ground. This includes the first four pins, whatever `port_sel`, `psave` or `blank` hold.
- R10: `port_sel` sets how many of pins 1–4 act as ports: 000 gives none, 001 gives pin 1, 010 gives pins 1–2, 011 gives pins 1–3, 100 gives pins 1–4. Codes 101–111 give none.
- R11: A port pin outputs full supply when its bit is 1 and ground when it is 0. `blank` does not affect it. In static drive, pins 1–4 take D1–D4. In two-phase drive, they take D1, D3, D5 and D7.
- R12: No output pin ever carries level code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | Single-cycle frame-timing enable |
| inhibit_n | input | 1 | Active-low display inhibit |
| disp_bits | input | 108 | Display bits; bit i holds D(i+1) |
| rate_sel | input | 3 | Frame divisor selector |
| duty2 | input | 1 | 0 = static drive, 1 = two-phase drive |
| blank | input | 1 | 1 = segment off waveform on all segments |
| psave | input | 1 | 1 = power-save mode |
| port_sel | input | 3 | Number of leading pins used as ports |
| com_lvl | output | 4 | Common level codes; common k at [2k+1:2k] |
| seg_lvl | output | 108 | Segment level codes; pin n at [2n-1:2n-2] |

## Verification
The assertions rest on these assumptions about the inputs:

- `osc_tick` and every control input are synchronous to `clk`.
- The control inputs change only between clock edges.
- The quarter position only steps forward by one, or holds.

The stimulus meets these assumptions. It changes every input one time unit after a rising edge. It also holds `rate_sel` steady across each frame-length measurement, so the measured interval covers only whole quarters.

// File: rtl/lcd_wave_pkg.sv
// Shared level codes and decode helpers for the LCD waveform generator.
// Assumes two commons and quarter lengths that never exceed QLEN_MAX.
package lcd_wave_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LV_GND  = 2'b00;
    localparam lvl_t LV_HALF = 2'b01;
    localparam lvl_t LV_FULL = 2'b10;

    localparam int NCOM     = 2;
    localparam int QLEN_MAX = 192;

    // Quarter length in ticks (frame divisor / 4); unknown codes use 384/4.
    function automatic int unsigned quarter_len(input logic [2:0] sel);
        case (sel)
            3'b110:  return 192;
            3'b111:  return 144;
            3'b001:  return 72;
            3'b010:  return 48;
            default: return 96;
        endcase
    endfunction

    // Number of leading pins acting as ports; codes above 4 give none.
    function automatic logic [2:0] port_count(input logic [2:0] sel);
        return (sel <= 3'd4) ? sel : 3'd0;
    endfunction

    // Opposite supply rail of a full/ground level.
    function automatic lvl_t flip_rail(input lvl_t rail);
        return (rail == LV_FULL) ? LV_GND : LV_FULL;
    endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
// Frame timer: counts accepted ticks within a quarter and steps a 2-bit
// quarter index. Assumes tick is a one-cycle enable synchronous to clk.
module lcd_frame_timer
    import lcd_wave_pkg::*;
#(
    parameter int QMAX  = QLEN_MAX,
    localparam int CNT_W = $clog2(QMAX)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic [2:0] rate_sel,
    output logic [1:0] phase
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Terminal count of the quarter for the current selector.
    assign last = CNT_W'(quarter_len(rate_sel) - 1);

    // Advance the tick count; wrap and step the quarter at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 2'd0;
        end else if (tick && run) begin
            if (cnt >= last) begin
                cnt   <= '0;
                phase <= phase + 2'd1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_com_drive.sv
// Common drivers: produce both common level codes from the quarter index
// and the drive mode, plus the rail of the currently selected common.
// Assumes phase[1] gives the polarity and phase[0] the selected common.
module lcd_com_drive
    import lcd_wave_pkg::*;
(
    input  logic [1:0]        phase,
    input  logic              duty2,
    input  logic              active,
    output logic [2*NCOM-1:0] com_lvl,
    output lvl_t              ref_rail
);

    // Rail of the selected common: full in the first half frame.
    assign ref_rail = phase[1] ? LV_GND : LV_FULL;

    for (genvar k = 0; k < NCOM; k++) begin : g_com
        // Level for common k under the overrides and drive mode.
        always_comb begin
            if (!active) begin
                com_lvl[2*k +: 2] = LV_GND;
            end else if (!duty2) begin
                com_lvl[2*k +: 2] = (k == 0) ? ref_rail : LV_GND;
            end else begin
                com_lvl[2*k +: 2] = (phase[0] == 1'(k)) ? ref_rail : LV_HALF;
            end
        end
    end

endmodule

// File: rtl/lcd_seg_drive.sv
// Segment drivers: pick each pin's display bit for the drive mode and the
// selected common, apply the overrides, and remap leading pins to ports.
// Assumes ref_rail is always LV_FULL or LV_GND.
module lcd_seg_drive
    import lcd_wave_pkg::*;
#(
    parameter int SEG_N  = 54,
    parameter int PORT_N = 4
) (
    input  logic               sub,
    input  lvl_t               ref_rail,
    input  logic               duty2,
    input  logic               blank,
    input  logic               psave,
    input  logic               inhibit_n,
    input  logic [2:0]         port_sel,
    input  logic [2*SEG_N-1:0] disp,
    output logic [2*SEG_N-1:0] seg_lvl
);

    logic [2:0] port_num;

    // Decoded number of leading pins acting as ports.
    assign port_num = port_count(port_sel);

    for (genvar n = 0; n < SEG_N; n++) begin : g_seg
        logic bit_sel;
        logic is_port;
        logic port_bit;

        // Display bit for the present common and drive mode.
        assign bit_sel = duty2 ? (sub ? disp[2*n+1] : disp[2*n]) : disp[n];

        if (n < PORT_N) begin : g_port
            // Port role and its data bit for the leading pins.
            assign is_port  = inhibit_n && (3'(n) < port_num);
            assign port_bit = duty2 ? disp[2*n] : disp[n];
        end else begin : g_plain
            assign is_port  = 1'b0;
            assign port_bit = 1'b0;
        end

        // Final level: port data, forced ground, or segment waveform.
        always_comb begin
            if (is_port) begin
                seg_lvl[2*n +: 2] = port_bit ? LV_FULL : LV_GND;
            end else if (!inhibit_n || psave) begin
                seg_lvl[2*n +: 2] = LV_GND;
            end else if (bit_sel && !blank) begin
                seg_lvl[2*n +: 2] = flip_rail(ref_rail);
            end else begin
                seg_lvl[2*n +: 2] = ref_rail;
            end
        end
    end

endmodule

// File: rtl/lcd_wave_gen.sv
// LCD waveform generator top: frame timer, common drivers and segment
// drivers. Outputs are combinational from the quarter register and inputs.
// Assumes all inputs are synchronous to clk.
module lcd_wave_gen
    import lcd_wave_pkg::*;
#(
    parameter int SEG_N  = 54,
    parameter int PORT_N = 4,
    localparam int DISP_W = 2 * SEG_N,
    localparam int SEG_W  = 2 * SEG_N,
    localparam int COM_W  = 2 * NCOM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              inhibit_n,
    input  logic [DISP_W-1:0] disp_bits,
    input  logic [2:0]        rate_sel,
    input  logic              duty2,
    input  logic              blank,
    input  logic              psave,
    input  logic [2:0]        port_sel,
    output logic [COM_W-1:0]  com_lvl,
    output logic [SEG_W-1:0]  seg_lvl
);

    logic [1:0] phase;
    logic       active;
    lvl_t       ref_rail;

    // Panel drive runs only when not inhibited and not in power save.
    assign active = inhibit_n && !psave;

    lcd_frame_timer #(.QMAX(QLEN_MAX)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_tick),
        .run      (active),
        .rate_sel (rate_sel),
        .phase    (phase)
    );

    lcd_com_drive u_com (
        .phase    (phase),
        .duty2    (duty2),
        .active   (active),
        .com_lvl  (com_lvl),
        .ref_rail (ref_rail)
    );

    lcd_seg_drive #(.SEG_N(SEG_N), .PORT_N(PORT_N)) u_seg (
        .sub       (phase[0]),
        .ref_rail  (ref_rail),
        .duty2     (duty2),
        .blank     (blank),
        .psave     (psave),
        .inhibit_n (inhibit_n),
        .port_sel  (port_sel),
        .disp      (disp_bits),
        .seg_lvl   (seg_lvl)
    );

endmodule

// File: rtl/lcd_wave_chk.sv
// Assertion checker for lcd_wave_gen, attached with bind below.
// Assumes inputs change only between clock edges.
module lcd_wave_chk #(
    parameter int SEG_N = 54
) (
    input logic               clk,
    input logic               rst_n,
    input logic               osc_tick,
    input logic               inhibit_n,
    input logic               duty2,
    input logic               blank,
    input logic               psave,
    input logic [3:0]         com_lvl,
    input logic [2*SEG_N-1:0] seg_lvl,
    input logic [1:0]         phase
);

    logic       seen;
    logic [1:0] com_half;
    logic       bad_code;

    // Marks that at least one cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // Flags for commons sitting at half supply.
    always_comb begin
        com_half[0] = (com_lvl[1:0] == 2'b01);
        com_half[1] = (com_lvl[3:2] == 2'b01);
    end

    // Detects the unused level code on any pin.
    always_comb begin
        bad_code = (com_lvl[1:0] == 2'b11) || (com_lvl[3:2] == 2'b11);
        for (int i = 0; i < SEG_N; i++) begin
            if (seg_lvl[2*i +: 2] == 2'b11) bad_code = 1'b1;
        end
    end

    // R2
    quarter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && phase != $past(phase)) |-> (phase == $past(phase) + 2'd1));

    // R2
    quarter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_tick && inhibit_n && !psave) |=> $stable(phase));

    // R9
    inhibit_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n |-> (com_lvl == '0 && seg_lvl == '0));

    // R8
    psave_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && psave) |-> (com_lvl == '0 && seg_lvl[2*SEG_N-1:8] == '0));

    // R3
    static_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && !psave && !duty2) |-> (com_lvl[3:2] == 2'b00 && !com_half[0]));

    // R5
    twophase_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && !psave && duty2) |-> ($countones(com_half) == 1));

    // R7
    blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && !psave && blank && !duty2) |-> (seg_lvl[9:8] == com_lvl[1:0]));

    // R12
    level_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_code);

endmodule

bind lcd_wave_gen lcd_wave_chk #(.SEG_N(SEG_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .inhibit_n (inhibit_n),
    .duty2     (duty2),
    .blank     (blank),
    .psave     (psave),
    .com_lvl   (com_lvl),
    .seg_lvl   (seg_lvl),
    .phase     (phase)
);

// File: tb/lcd_wave_gen_test.sv
// Bench for lcd_wave_gen: behavioural frame model compared every cycle,
// plus directed frame-length and tick-gating checks.
module lcd_wave_gen_test;

    localparam int SEG_N = 54;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         osc_tick = 1'b0;
    logic         inhibit_n = 1'b0;
    logic [107:0] disp_bits = '0;
    logic [2:0]   rate_sel = 3'b000;
    logic         duty2 = 1'b0;
    logic         blank = 1'b0;
    logic         psave = 1'b0;
    logic [2:0]   port_sel = 3'b000;
    logic [3:0]   com_lvl;
    logic [107:0] seg_lvl;

    int checks = 0;
    int errors = 0;
    int tick_mode = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    int m_cnt = 0;
    int m_q = 0;
    logic [3:0]   ec;
    logic [107:0] es;

    lcd_wave_gen #(.SEG_N(SEG_N)) uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .inhibit_n(inhibit_n),
        .disp_bits(disp_bits), .rate_sel(rate_sel), .duty2(duty2), .blank(blank),
        .psave(psave), .port_sel(port_sel), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    always #5 clk = ~clk;

    function automatic int qlen(input logic [2:0] s);
        case (s)
            3'b110: return 192;
            3'b111: return 144;
            3'b001: return 72;
            3'b010: return 48;
            default: return 96;
        endcase
    endfunction

    function automatic int nports();
        return (port_sel <= 3'd4) ? int'(port_sel) : 0;
    endfunction

    function automatic int rail();
        return (m_q < 2) ? 2 : 0;
    endfunction

    function automatic int e_com(input int k);
        if (!inhibit_n || psave) return 0;
        if (!duty2) return (k == 0) ? rail() : 0;
        return (k == m_q % 2) ? rail() : 1;
    endfunction

    function automatic int e_seg(input int n);
        logic b;
        if (!inhibit_n) return 0;
        if (n < 4 && n < nports()) begin
            b = duty2 ? disp_bits[2*n] : disp_bits[n];
            return b ? 2 : 0;
        end
        if (psave) return 0;
        b = duty2 ? disp_bits[2*n + m_q % 2] : disp_bits[n];
        if (b && !blank) return (rail() == 2) ? 0 : 2;
        return rail();
    endfunction

    function automatic string com_tag();
        if (!inhibit_n) return "R9";
        if (psave) return "R8";
        return duty2 ? "R5" : "R3";
    endfunction

    function automatic string seg_tag(input int n);
        if (!inhibit_n) return "R9";
        if (n < 4 && n < nports()) return "R11";
        if (n < 4) return "R10";
        if (psave) return "R8";
        if (blank) return "R7";
        return duty2 ? "R6" : "R4";
    endfunction

    // Reference frame position (R1, R2).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_q = 0;
        end else if (osc_tick && inhibit_n && !psave) begin
            if (m_cnt >= qlen(rate_sel) - 1) begin
                m_cnt = 0;
                m_q = (m_q + 1) % 4;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    // Tick pattern generator.
    always @(posedge clk) begin
        #1;
        case (tick_mode)
            1: osc_tick = 1'b1;
            2: osc_tick = ~osc_tick;
            default: osc_tick = 1'b0;
        endcase
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_on) begin
            for (int k = 0; k < 2; k++) ec[2*k +: 2] = 2'(e_com(k));
            for (int n = 0; n < SEG_N; n++) es[2*n +: 2] = 2'(e_seg(n));
            checks++;
            if (com_lvl !== ec) begin
                errors++;
                $display("FAIL %s com actual=%h expected=%h q=%0d", com_tag(), com_lvl, ec, m_q);
            end
            checks++;
            if (seg_lvl !== es) begin
                errors++;
                for (int n = 0; n < SEG_N; n++) begin
                    if (seg_lvl[2*n +: 2] !== es[2*n +: 2]) begin
                        $display("FAIL %s seg pin %0d actual=%b expected=%b", seg_tag(n), n + 1,
                                 seg_lvl[2*n +: 2], es[2*n +: 2]);
                        break;
                    end
                end
            end
            checks++;
            for (int n = 0; n < SEG_N; n++) begin
                if (seg_lvl[2*n +: 2] === 2'b11) begin
                    errors++;
                    $display("FAIL R12 seg pin %0d actual=11 expected=not 11", n + 1);
                    break;
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_pattern(input int seed);
        for (int i = 0; i < 108; i++) disp_bits[i] = (((i * 7 + seed) % 5) < 2);
    endtask

    // R1: measure one half frame in static drive with a tick every cycle.
    task automatic measure(input logic [2:0] sel, input int exp_half);
        logic [1:0] prev;
        int n;
        rate_sel = sel;
        @(negedge clk);
        prev = com_lvl[1:0];
        n = 0;
        while (com_lvl[1:0] === prev && n < 2000) begin @(negedge clk); n++; end
        prev = com_lvl[1:0];
        n = 0;
        do begin @(negedge clk); n++; end while (com_lvl[1:0] === prev && n < 2000);
        checks++;
        if (n != exp_half) begin
            errors++;
            $display("FAIL R1 half frame sel=%b actual=%0d expected=%0d", sel, n, exp_half);
        end
        step(1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0]   hc;
        logic [107:0] hs;
        step(4);
        // Reset state with inhibit low: everything at ground (R9).
        @(negedge clk);
        checks++;
        if (com_lvl !== 4'h0 || seg_lvl !== '0) begin
            errors++;
            $display("FAIL R9 reset actual=%h/%h expected=0/0", com_lvl, seg_lvl);
        end
        step(1);
        rst_n = 1'b1;
        chk_on = 1'b1;
        inhibit_n = 1'b1;
        load_pattern(1);
        tick_mode = 1;
        step(900);

        // R1 frame lengths, including undefined codes.
        measure(3'b110, 384);
        measure(3'b111, 288);
        measure(3'b000, 192);
        measure(3'b001, 144);
        measure(3'b010, 96);
        measure(3'b011, 192);
        measure(3'b101, 192);

        // Every other cycle ticks, then a mid-quarter rate change.
        tick_mode = 2;
        rate_sel = 3'b110;
        load_pattern(3);
        step(700);
        rate_sel = 3'b010;
        step(300);

        // R2: no ticks, outputs hold.
        tick_mode = 0;
        step(2);
        @(negedge clk);
        hc = com_lvl;
        hs = seg_lvl;
        step(300);
        @(negedge clk);
        checks++;
        if (com_lvl !== hc || seg_lvl !== hs) begin
            errors++;
            $display("FAIL R2 hold actual=%h expected=%h", com_lvl, hc);
        end
        step(1);
        tick_mode = 1;

        // Two-phase drive (R5, R6).
        duty2 = 1'b1;
        rate_sel = 3'b010;
        load_pattern(2);
        step(600);
        load_pattern(4);
        rate_sel = 3'b001;
        step(600);

        // Blanking (R7) in both modes.
        blank = 1'b1;
        step(400);
        duty2 = 1'b0;
        rate_sel = 3'b010;
        step(400);
        blank = 1'b0;

        // Port counts (R10, R11) in both modes.
        for (int m = 0; m < 2; m++) begin
            duty2 = m[0];
            for (int p = 1; p <= 6; p++) begin
                port_sel = 3'(p);
                load_pattern(p + m);
                step(150);
            end
        end
        blank = 1'b1;
        port_sel = 3'b100;
        step(150);
        blank = 1'b0;

        // Power save with ports (R8), then resume.
        psave = 1'b1;
        step(300);
        psave = 1'b0;
        step(200);

        // Inhibit overrides ports, power save and blanking (R9).
        inhibit_n = 1'b0;
        psave = 1'b1;
        blank = 1'b1;
        step(200);
        psave = 1'b0;
        blank = 1'b0;
        step(100);
        inhibit_n = 1'b1;
        duty2 = 1'b1;
        step(400);

        chk_on = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule